// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits between a MAC receive parser and the application-side delivery path. For each received frame it decides whether the frame is delivered or discarded. It also reports whether the destination was a broadcast or a multicast address, and it tells the delivery path whether to remove pad bytes and CRC bytes. The parser marks the frame with a start strobe (`sof_i`) and an end strobe (`eof_i`). When `eof_i` is asserted, the parser also presents the destination address, the frame length and a CRC-valid flag.

Configuration arrives as a 32-bit receive-control word, a 48-bit filter address and a 48-bit compare mask. The block copies all three into a shadow at the start of each frame, so a frame is always judged against one consistent set of settings. A three-state machine controls the flow. `ST_IDLE` waits for a frame. `ST_FRAME` is the frame in progress. `ST_REPORT` holds the verdict for exactly one cycle.

The transitions are:
- `ST_IDLE` to `ST_FRAME` on `sof_i` ("open"), which also captures the configuration.
- `ST_FRAME` to `ST_REPORT` on `eof_i` ("close"), which registers the verdict.
- `ST_REPORT` back to `ST_IDLE` ("retire"), or straight to `ST_FRAME` when `sof_i` is present ("reopen").

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, `res_vld_o`, `accept_o`, `bcast_o`, `mcast_o`, `strip_pad_o` and `strip_crc_o` are all 0.
- R2: When control bit 0 (receive enable) is 0, `accept_o` is 0 for every frame.
- R3: A broadcast frame is dropped only when control bit 7 (broadcast reject) is 1, control bit 5 (address filter enable) is 1 and the mask is non-zero. Otherwise it is accepted, provided the other checks pass.
- R4: With a zero mask and broadcast reject set, a broadcast frame is still accepted, with `bcast_o`=1 and `mcast_o`=0.
- R5: With control bit 5 set, a non-broadcast frame is accepted only if (dest & mask) equals (filter address & mask) over all 48 bits. With bit 5 clear, every non-broadcast frame passes this check.
- R6: A destination of all ones sets `bcast_o`. A destination with bit 40 set (the least significant bit of the first byte, address bits 47:40) that is not all ones sets `mcast_o`. The two flags are never 1 together, and both are reported whether or not the frame is accepted.
- R7: A frame shorter than 64 bytes is dropped when control bit 6 (keep runts) is 0 and may be accepted when it is 1. A 64-byte frame is not a runt.
- R8: A frame whose CRC-valid flag is 0 is dropped.
- R9: With the verdict, `strip_pad_o` equals control bit 1 and `strip_crc_o` equals the inverse of control bit 2 (CRC forwarding).
- R10: The verdict and flags appear with `res_vld_o`=1 in the cycle after the edge that samples `eof_i`. `res_vld_o` is 1 for that single cycle and 0 in the next.
- R11: Configuration is captured at `sof_i`. Changes to the control word, filter address or mask during a frame have no effect on that frame's verdict.
- R12: An `eof_i` outside a frame (in `ST_IDLE`) produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Frame start strobe |
| eof_i | input | 1 | Frame end strobe; frame fields are valid with it |
| dest_i | input | 48 | Destination address, first byte in bits 47:40 |
| len_i | input | 16 | Frame length in bytes, CRC included |
| crc_ok_i | input | 1 | Frame CRC is valid |
| ctrl_i | input | 32 | Receive-control word |
| filt_addr_i | input | 48 | Filter compare address |
| filt_mask_i | input | 48 | Filter compare mask (1 = compare bit) |
| res_vld_o | output | 1 | Verdict valid, one cycle |
| accept_o | output | 1 | Frame is delivered |
| bcast_o | output | 1 | Destination is broadcast |
| mcast_o | output | 1 | Destination is multicast |
| strip_pad_o | output | 1 | Remove pad bytes from delivered data |
| strip_crc_o | output | 1 | Remove CRC bytes from delivered data |

## Verification
The assertions check the following on every cycle:
- `res_vld_o` is a single-cycle pulse that only ever follows `eof_i`.
- No frame is accepted while the captured receive enable is clear.
- The broadcast and multicast flags are never set together.
- An accepted broadcast never coincides with the full three-way reject condition.
- The captured configuration stays still through a frame.

Only the bench's scenarios can show the full verdict for specific address, mask, length and CRC combinations. The same holds for the zero-mask override, the 63/64-byte runt boundary, stray end strobes, and immunity to mid-frame configuration changes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int CTRL_W  = 32;
    localparam int ADDR_W  = 48;
    localparam int LEN_W   = 16;

    // control word bit positions
    localparam int B_RXEN  = 0;
    localparam int B_PAD   = 1;
    localparam int B_FWCRC = 2;
    localparam int B_PAUSE = 3;
    localparam int B_LOOP  = 4;
    localparam int B_FILT  = 5;
    localparam int B_RUNT  = 6;
    localparam int B_BREJ  = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRAME  = 2'd1,
        ST_REPORT = 2'd2
    } rxf_state_e;

    typedef struct packed {
        logic              rx_en;
        logic              pad_strip;
        logic              fwd_crc;
        logic              filt_en;
        logic              keep_runt;
        logic              bc_reject;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
    } rxf_cfg_t;

endpackage

// File: rtl/rxf_cfg_shadow.sv
module rxf_cfg_shadow
    import rxf_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] ctrl_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] mask_i,
    output rxf_cfg_t      cfg_o
);

    rxf_cfg_t next_cfg;

    always_comb begin
        next_cfg.rx_en     = ctrl_i[B_RXEN];
        next_cfg.pad_strip = ctrl_i[B_PAD];
        next_cfg.fwd_crc   = ctrl_i[B_FWCRC];
        next_cfg.filt_en   = ctrl_i[B_FILT];
        next_cfg.keep_runt = ctrl_i[B_RUNT];
        next_cfg.bc_reject = ctrl_i[B_BREJ];
        next_cfg.addr      = addr_i;
        next_cfg.mask      = mask_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_o <= '0;
        end else if (load_i) begin
            cfg_o <= next_cfg;
        end
    end

endmodule

// File: rtl/rxf_addr_class.sv
module rxf_addr_class #(
    parameter int AW = 48
) (
    input  logic [AW-1:0] dest_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] mask_i,
    output logic          bcast_o,
    output logic          mcast_o,
    output logic          match_o,
    output logic          mask_nz_o
);

    localparam int GROUP_BIT = AW - 8;

    always_comb begin
        bcast_o   = &dest_i;
        mcast_o   = dest_i[GROUP_BIT] && !bcast_o;
        match_o   = ((dest_i ^ addr_i) & mask_i) == '0;
        mask_nz_o = |mask_i;
    end

endmodule

// File: rtl/rxf_accept.sv
module rxf_accept
    import rxf_pkg::*;
#(
    parameter int LW      = LEN_W,
    parameter int MIN_LEN = 64
) (
    input  rxf_cfg_t      cfg_i,
    input  logic [LW-1:0] len_i,
    input  logic          crc_ok_i,
    input  logic          bcast_i,
    input  logic          match_i,
    input  logic          mask_nz_i,
    output logic          accept_o
);

    localparam logic [LW-1:0] MIN_L = LW'(MIN_LEN);

    logic is_runt;
    logic len_ok;
    logic addr_ok;

    always_comb begin
        is_runt = len_i < MIN_L;
        len_ok  = !is_runt || cfg_i.keep_runt;
        if (bcast_i) begin
            addr_ok = !(cfg_i.bc_reject && cfg_i.filt_en && mask_nz_i);
        end else begin
            addr_ok = !cfg_i.filt_en || match_i;
        end
        accept_o = cfg_i.rx_en && crc_ok_i && len_ok && addr_ok;
    end

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int CW      = CTRL_W,
    parameter int AW      = ADDR_W,
    parameter int LW      = LEN_W,
    parameter int MIN_LEN = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sof_i,
    input  logic          eof_i,
    input  logic [AW-1:0] dest_i,
    input  logic [LW-1:0] len_i,
    input  logic          crc_ok_i,
    input  logic [CW-1:0] ctrl_i,
    input  logic [AW-1:0] filt_addr_i,
    input  logic [AW-1:0] filt_mask_i,
    output logic          res_vld_o,
    output logic          accept_o,
    output logic          bcast_o,
    output logic          mcast_o,
    output logic          strip_pad_o,
    output logic          strip_crc_o
);

    rxf_state_e state_q, state_d;
    rxf_cfg_t   cfg_q;
    logic       cfg_load;
    logic       close_frame;
    logic       c_bcast, c_mcast, c_match, c_mask_nz;
    logic       c_accept;

    assign cfg_load    = sof_i && (state_q != ST_FRAME);
    assign close_frame = eof_i && (state_q == ST_FRAME);

    rxf_cfg_shadow #(.CW(CW), .AW(AW)) u_shadow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (cfg_load),
        .ctrl_i (ctrl_i),
        .addr_i (filt_addr_i),
        .mask_i (filt_mask_i),
        .cfg_o  (cfg_q)
    );

    rxf_addr_class #(.AW(AW)) u_class (
        .dest_i    (dest_i),
        .addr_i    (cfg_q.addr),
        .mask_i    (cfg_q.mask),
        .bcast_o   (c_bcast),
        .mcast_o   (c_mcast),
        .match_o   (c_match),
        .mask_nz_o (c_mask_nz)
    );

    rxf_accept #(.LW(LW), .MIN_LEN(MIN_LEN)) u_accept (
        .cfg_i     (cfg_q),
        .len_i     (len_i),
        .crc_ok_i  (crc_ok_i),
        .bcast_i   (c_bcast),
        .match_i   (c_match),
        .mask_nz_i (c_mask_nz),
        .accept_o  (c_accept)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sof_i) state_d = ST_FRAME;
            ST_FRAME:  if (eof_i) state_d = ST_REPORT;
            ST_REPORT: state_d = sof_i ? ST_FRAME : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_vld_o   <= 1'b0;
            accept_o    <= 1'b0;
            bcast_o     <= 1'b0;
            mcast_o     <= 1'b0;
            strip_pad_o <= 1'b0;
            strip_crc_o <= 1'b0;
        end else if (close_frame) begin
            res_vld_o   <= 1'b1;
            accept_o    <= c_accept;
            bcast_o     <= c_bcast;
            mcast_o     <= c_mcast;
            strip_pad_o <= cfg_q.pad_strip;
            strip_crc_o <= !cfg_q.fwd_crc;
        end else begin
            res_vld_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       eof_i,
    input rxf_state_e state_q,
    input rxf_cfg_t   cfg_q,
    input logic       res_vld_o,
    input logic       accept_o,
    input logic       bcast_o,
    input logic       mcast_o
);

    p_vld_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_vld_o |=> !res_vld_o);

    p_vld_after_eof_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_vld_o |-> $past(eof_i));

    p_rx_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_vld_o && !cfg_q.rx_en) |-> !accept_o);

    p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({bcast_o, mcast_o}));

    p_bcast_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_vld_o && bcast_o && accept_o)
            |-> !(cfg_q.bc_reject && cfg_q.filt_en && (cfg_q.mask != '0)));

    p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FRAME) |=> $stable(cfg_q));

endmodule

bind rx_frame_filter rxf_checker #(.AW(AW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eof_i     (eof_i),
    .state_q   (state_q),
    .cfg_q     (cfg_q),
    .res_vld_o (res_vld_o),
    .accept_o  (accept_o),
    .bcast_o   (bcast_o),
    .mcast_o   (mcast_o)
);

// File: tb/tb_rx_frame_filter.sv
module tb_rx_frame_filter;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 15;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [47:0] da;
        logic [47:0] fa;
        logic [47:0] mask;
        logic [15:0] len;
        logic        crc;
        logic        e_acc;
        logic        e_bc;
        logic        e_mc;
    } vec_t;

    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC = 48'h0100_5E00_0001;
    localparam logic [47:0] UC = 48'h0012_3456_789A;
    localparam logic [47:0] UX = 48'h0012_3456_7800;
    localparam logic [47:0] MF = 48'hFFFF_FFFF_FFFF;

    localparam vec_t TBL [NV] = '{
        '{8'h03, UC, 48'h0, MF, 16'd100, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 filter off, R9
        '{8'h00, UC, 48'h0, MF, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
        '{8'h21, UC, UC,    MF, 16'd100, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 match
        '{8'h21, UX, UC,    MF, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 mismatch
        '{8'h21, UX, UC, 48'hFFFF_FFFF_FF00, 16'd100, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 masked
        '{8'hA1, BC, UC,    MF, 16'd100, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 reject
        '{8'h81, BC, UC,    MF, 16'd100, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 filter off
        '{8'hA1, BC, UC, 48'h0, 16'd100, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 zero mask
        '{8'h21, BC, UC,    MF, 16'd100, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 no reject bit
        '{8'h05, MC, 48'h0, MF, 16'd100, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 multicast, R9
        '{8'h01, UC, 48'h0, MF, 16'd63,  1'b1, 1'b0, 1'b0, 1'b0}, // R7 runt drop
        '{8'h41, UC, 48'h0, MF, 16'd63,  1'b1, 1'b1, 1'b0, 1'b0}, // R7 runt keep
        '{8'h01, UC, 48'h0, MF, 16'd64,  1'b1, 1'b1, 1'b0, 1'b0}, // R7 boundary
        '{8'h01, UC, 48'h0, MF, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 bad CRC
        '{8'h21, MC, UC, 48'h0, 16'd100, 1'b1, 1'b1, 1'b0, 1'b1}  // R6 flags with R5 zero mask
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof, eof, crc_ok;
    logic [47:0] dest, faddr, fmask;
    logic [15:0] len;
    logic [31:0] ctrl;
    logic        vld, acc, bc, mc, spad, scrc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_filter dut (
        .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .eof_i(eof),
        .dest_i(dest), .len_i(len), .crc_ok_i(crc_ok), .ctrl_i(ctrl),
        .filt_addr_i(faddr), .filt_mask_i(fmask),
        .res_vld_o(vld), .accept_o(acc), .bcast_o(bc), .mcast_o(mc),
        .strip_pad_o(spad), .strip_crc_o(scrc)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // frame opened at sof, closed at eof; returns with outputs in report cycle
    task automatic run_frame(input vec_t v, input logic [7:0] mid_ctrl, input bit change);
        @(negedge clk);
        ctrl = {24'h0, v.ctrl}; faddr = v.fa; fmask = v.mask; sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        if (change) begin
            ctrl = {24'h0, mid_ctrl}; faddr = ~v.fa; fmask = ~v.mask;
        end
        dest = v.da; len = v.len; crc_ok = v.crc; eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
    endtask

    initial begin
        sof = 0; eof = 0; crc_ok = 0; dest = '0; len = '0;
        ctrl = '0; faddr = '0; fmask = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "vld", vld, 1'b0);
        chk("R1", "accept", acc, 1'b0);
        chk("R1", "bcast", bc, 1'b0);
        chk("R1", "mcast", mc, 1'b0);
        chk("R1", "strip_pad", spad, 1'b0);
        chk("R1", "strip_crc", scrc, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_frame(TBL[i], 8'h00, 1'b0);
            chk("R10", $sformatf("vec%0d vld", i), vld, 1'b1);
            chk("R2-R8", $sformatf("vec%0d accept", i), acc, TBL[i].e_acc);
            chk("R6", $sformatf("vec%0d bcast", i), bc, TBL[i].e_bc);
            chk("R6", $sformatf("vec%0d mcast", i), mc, TBL[i].e_mc);
            chk("R9", $sformatf("vec%0d strip_pad", i), spad, TBL[i].ctrl[1]);
            chk("R9", $sformatf("vec%0d strip_crc", i), scrc, !TBL[i].ctrl[2]);
            @(negedge clk);
            chk("R10", $sformatf("vec%0d vld drop", i), vld, 1'b0);
        end

        // R11: settings changed mid-frame must not affect the verdict
        run_frame('{8'h21, UC, UC, MF, 16'd100, 1'b1, 1'b1, 1'b0, 1'b0}, 8'h00, 1'b1);
        chk("R11", "vld", vld, 1'b1);
        chk("R11", "accept with captured cfg", acc, 1'b1);
        chk("R11", "strip_crc captured", scrc, 1'b1);
        @(negedge clk);

        // R12: stray end strobe in idle gives no verdict
        eof = 1'b1; dest = UC; len = 16'd100; crc_ok = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        chk("R12", "vld after stray eof", vld, 1'b0);
        @(negedge clk);
        chk("R12", "vld one later", vld, 1'b0);

        // R2 again after enabled frames: disable blocks a clean unicast
        run_frame('{8'h06, UC, 48'h0, MF, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0}, 8'h00, 1'b0);
        chk("R2", "accept while disabled", acc, 1'b0);
        chk("R9", "strip_pad", spad, 1'b1);
        chk("R9", "strip_crc", scrc, 1'b0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule